// File: doc/BRIEF.md
# Multi-Mode Programmable Delay Timer

This block is a ladder-logic style timer for sequential control. It has one enable input, a preset in whole seconds and a 2-bit mode select. A prescaler divides the system clock down to a base tick of one tenth of a second, and a single elapsed counter advances on that tick. The counter limit is the preset times ten.

Four behaviours share the counter, and they differ in how enable edges act on it. On-delay holds the output back until enable has stayed high for the preset time. Off-delay keeps the output high for the preset time after enable falls. The retriggerable monostable fires a pulse on every rising enable edge. Single-shot fires one pulse per enable assertion. The elapsed count is brought out beside the output bit so that it can be observed.

The preset and the mode are plain input ports. Any change of mode puts the timer back to rest, and the new mode applies from the next cycle.

Top module: `ptmr_top`

## Requirements
- R1: The elapsed count advances by one on each base tick, and a base tick occurs once every TICK_DIV clock cycles. The limit compared against is preset × 10 base ticks, so a preset of 2 gives a delay between 77 and 80 clocks when TICK_DIV = 4.
- R2: Mode 2'b00 (on-delay): the output goes high only once enable has been high continuously for the limit.
- R3: In on-delay mode a low enable drives the output low and clears the elapsed count, both on the next clock edge.
- R4: Mode 2'b01 (off-delay): the output is high one clock after enable is high. After enable falls, the output stays high until the limit has elapsed and then goes low.
- R5: Mode 2'b10 (retriggerable monostable): a rising enable edge sets the output high on the next clock edge. The output goes low once the limit has elapsed, even while enable stays high.
- R6: In monostable mode, every low-to-high enable transition, including one during a running pulse, restarts the count and keeps or sets the output high.
- R7: Mode 2'b11 (single-shot): a high enable starts one pulse of the limit length. A done flag is latched at the end of the pulse and prevents another pulse while enable stays high. Toggling enable during the pulse does not lengthen it.
- R8: In single-shot mode the done flag clears only when enable is low and no pulse is running, after which a high enable fires a new pulse.
- R9: A change of the mode input clears the output, the elapsed count and the done flag on the next edge. The new mode counts an enable that is already high as a level and not as a rising edge.
- R10: A preset of zero makes the on-delay output follow enable one clock later, and makes the monostable produce no pulse.
- R11: The elapsed count saturates at the limit and never wraps while enable is held.
- R12: While synchronous reset is high, the output is 0 and the elapsed count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Timer enable |
| mode_i | input | 2 | 00 on-delay, 01 off-delay, 10 monostable, 11 single-shot |
| preset_i | input | PRESET_W | Preset in seconds (units of 10 base ticks) |
| timer_o | output | 1 | Timer output bit |
| elapsed_o | output | CNT_W | Elapsed base ticks |

## Verification
A corrupted elapsed count shows at the ports in two ways: the output edge moves by whole base ticks, or the elapsed value read after saturation or after a clear is wrong. This becomes visible within one preset interval. A stuck done flag or a missed enable edge shows as a pulse that is missing or repeated within one clock of the enable change. A faulty prescaler stretches or shrinks every delay, so the windows at presets of 1 and 2 are checked against bounds of plus or minus one tick.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        MODE_ON_DELAY  = 2'b00,
        MODE_OFF_DELAY = 2'b01,
        MODE_MONO      = 2'b10,
        MODE_ONESHOT   = 2'b11
    } tmr_mode_e;

    localparam int unsigned WIDE_W = 32;

    // Saturating step of the elapsed counter.
    function automatic logic [WIDE_W-1:0] sat_step(
        input logic [WIDE_W-1:0] cur,
        input logic [WIDE_W-1:0] lim,
        input logic              tick
    );
        if (tick && (cur < lim)) begin
            return cur + 32'd1;
        end
        return cur;
    endfunction

endpackage

// File: rtl/ptmr_tick.sv
module ptmr_tick #(
    parameter int unsigned TICK_DIV = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int unsigned DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
            logic [DIV_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == LAST);

            // R1
            tick_single_chk: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             out_o,
    output logic [CNT_W-1:0] elapsed_o
);
    tmr_mode_e        mode_q, mode_n;
    logic [CNT_W-1:0] elapsed_q, elapsed_n, stepped;
    logic             out_q, out_n, done_q, done_n, en_q;
    logic             rise, mode_chg, past_ok;
    logic [WIDE_W-1:0] wide_step;

    assign rise      = en_i & ~en_q;
    assign mode_chg  = (tmr_mode_e'(mode_i) != mode_q);
    assign wide_step = sat_step(WIDE_W'(elapsed_q), WIDE_W'(limit_i), tick_i);
    assign stepped   = wide_step[CNT_W-1:0];

    always_comb begin
        mode_n    = mode_q;
        elapsed_n = elapsed_q;
        out_n     = out_q;
        done_n    = done_q;
        if (mode_chg) begin
            mode_n    = tmr_mode_e'(mode_i);
            elapsed_n = '0;
            out_n     = 1'b0;
            done_n    = 1'b0;
        end else begin
            unique case (mode_q)
                MODE_ON_DELAY: begin
                    if (!en_i) begin
                        elapsed_n = '0;
                        out_n     = 1'b0;
                    end else begin
                        elapsed_n = stepped;
                        out_n     = (stepped >= limit_i);
                    end
                end
                MODE_OFF_DELAY: begin
                    if (en_i) begin
                        elapsed_n = '0;
                        out_n     = 1'b1;
                    end else if (out_q) begin
                        elapsed_n = stepped;
                        out_n     = (stepped < limit_i);
                    end
                end
                MODE_MONO: begin
                    if (rise) begin
                        elapsed_n = '0;
                        out_n     = (limit_i != '0);
                    end else if (out_q) begin
                        elapsed_n = stepped;
                        out_n     = (stepped < limit_i);
                    end
                end
                MODE_ONESHOT: begin
                    if (out_q) begin
                        elapsed_n = stepped;
                        out_n     = (stepped < limit_i);
                        if (!out_n) done_n = 1'b1;
                    end else if (en_i && !done_q) begin
                        elapsed_n = '0;
                        out_n     = (limit_i != '0);
                        if (limit_i == '0) done_n = 1'b1;
                    end else if (!en_i) begin
                        done_n = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_ON_DELAY;
            elapsed_q <= '0;
            out_q     <= 1'b0;
            done_q    <= 1'b0;
            en_q      <= 1'b0;
            past_ok   <= 1'b0;
        end else begin
            mode_q    <= mode_n;
            elapsed_q <= elapsed_n;
            out_q     <= out_n;
            done_q    <= done_n;
            en_q      <= en_i;
            past_ok   <= 1'b1;
        end
    end

    assign out_o     = out_q;
    assign elapsed_o = elapsed_q;

    // R3
    ondly_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ON_DELAY && !en_i) |=> (!out_q && elapsed_q == '0));

    // R4
    offdly_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OFF_DELAY && !mode_chg && en_i) |=> out_q);

    // R5
    mono_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_MONO && !mode_chg && rise && limit_i != '0) |=> out_q);

    // R7
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ONESHOT && !mode_chg && done_q && !out_q) |=> !out_q);

    // R11
    elapsed_step_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && elapsed_q > $past(elapsed_q)) |-> (elapsed_q == $past(elapsed_q) + CNT_W'(1)));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $stable(limit_i) && $past(elapsed_q) <= $past(limit_i)) |-> (elapsed_q <= limit_i));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
    parameter int unsigned TICK_DIV      = 12_500_000,
    parameter int unsigned PRESET_W      = 8,
    parameter int unsigned TICKS_PER_SEC = 10,
    localparam int unsigned CNT_W = $clog2(((2 ** PRESET_W) - 1) * TICKS_PER_SEC + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable_i,
    input  logic [1:0]          mode_i,
    input  logic [PRESET_W-1:0] preset_i,
    output logic                timer_o,
    output logic [CNT_W-1:0]    elapsed_o
);
    logic             tick;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(preset_i) * CNT_W'(TICKS_PER_SEC);

    ptmr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    ptmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .en_i      (enable_i),
        .mode_i    (mode_i),
        .limit_i   (limit),
        .out_o     (timer_o),
        .elapsed_o (elapsed_o)
    );
endmodule

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;
    localparam int unsigned DIV = 4;
    localparam int unsigned PW  = 4;
    localparam int unsigned CW  = $clog2(((2 ** PW) - 1) * 10 + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [PW-1:0] preset = '0;
    logic          tout;
    logic [CW-1:0] elapsed;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    ptmr_top #(.TICK_DIV(DIV), .PRESET_W(PW), .TICKS_PER_SEC(10)) u_dut (
        .clk(clk), .rst(rst), .enable_i(en), .mode_i(mode),
        .preset_i(preset), .timer_o(tout), .elapsed_o(elapsed)
    );

    typedef struct packed {
        logic [1:0] md;
        logic [3:0] pr;
        logic       e;
        logic [7:0] wt;
        logic       ex;
        logic [3:0] tag;
    } step_t;

    localparam int NS = 45;
    localparam step_t STEPS [NS] = '{
        '{2'b00, 4'd1, 1'b0, 8'd4,  1'b0, 4'd12},
        '{2'b00, 4'd1, 1'b1, 8'd34, 1'b0, 4'd2},  // R2 still low
        '{2'b00, 4'd1, 1'b1, 8'd10, 1'b1, 4'd2},  // R2 high after limit
        '{2'b00, 4'd1, 1'b0, 8'd1,  1'b0, 4'd3},  // R3 immediate drop
        '{2'b00, 4'd1, 1'b1, 8'd20, 1'b0, 4'd3},
        '{2'b00, 4'd1, 1'b0, 8'd1,  1'b0, 4'd3},
        '{2'b00, 4'd1, 1'b1, 8'd34, 1'b0, 4'd3},  // R3 count was cleared
        '{2'b00, 4'd1, 1'b1, 8'd10, 1'b1, 4'd2},
        '{2'b01, 4'd1, 1'b0, 8'd2,  1'b0, 4'd9},  // R9 mode change clears
        '{2'b01, 4'd1, 1'b1, 8'd1,  1'b1, 4'd4},  // R4 follows enable
        '{2'b01, 4'd1, 1'b0, 8'd34, 1'b1, 4'd4},  // R4 held after fall
        '{2'b01, 4'd1, 1'b0, 8'd10, 1'b0, 4'd4},  // R4 released
        '{2'b10, 4'd1, 1'b0, 8'd2,  1'b0, 4'd9},
        '{2'b10, 4'd1, 1'b1, 8'd1,  1'b1, 4'd5},  // R5 immediate
        '{2'b10, 4'd1, 1'b1, 8'd33, 1'b1, 4'd5},
        '{2'b10, 4'd1, 1'b1, 8'd10, 1'b0, 4'd5},  // R5 ends with enable high
        '{2'b10, 4'd1, 1'b0, 8'd20, 1'b0, 4'd5},
        '{2'b10, 4'd1, 1'b1, 8'd1,  1'b1, 4'd6},  // R6 new edge fires
        '{2'b10, 4'd1, 1'b1, 8'd20, 1'b1, 4'd6},
        '{2'b10, 4'd1, 1'b0, 8'd2,  1'b1, 4'd6},
        '{2'b10, 4'd1, 1'b1, 8'd30, 1'b1, 4'd6},  // R6 retrigger extends
        '{2'b10, 4'd1, 1'b1, 8'd14, 1'b0, 4'd6},
        '{2'b11, 4'd1, 1'b0, 8'd2,  1'b0, 4'd9},
        '{2'b11, 4'd1, 1'b1, 8'd1,  1'b1, 4'd7},  // R7 pulse starts
        '{2'b11, 4'd1, 1'b1, 8'd44, 1'b0, 4'd7},
        '{2'b11, 4'd1, 1'b1, 8'd50, 1'b0, 4'd7},  // R7 done blocks refire
        '{2'b11, 4'd1, 1'b0, 8'd2,  1'b0, 4'd8},
        '{2'b11, 4'd1, 1'b1, 8'd1,  1'b1, 4'd8},  // R8 done cleared by low
        '{2'b11, 4'd1, 1'b1, 8'd20, 1'b1, 4'd7},
        '{2'b11, 4'd1, 1'b0, 8'd2,  1'b1, 4'd7},
        '{2'b11, 4'd1, 1'b1, 8'd21, 1'b0, 4'd7},  // R7 no restart mid-pulse
        '{2'b00, 4'd1, 1'b0, 8'd2,  1'b0, 4'd9},
        '{2'b00, 4'd1, 1'b1, 8'd20, 1'b0, 4'd9},
        '{2'b10, 4'd1, 1'b1, 8'd30, 1'b0, 4'd9},  // R9 change mid-timing resets
        '{2'b10, 4'd1, 1'b1, 8'd30, 1'b0, 4'd9},
        '{2'b00, 4'd2, 1'b0, 8'd2,  1'b0, 4'd1},
        '{2'b00, 4'd2, 1'b1, 8'd74, 1'b0, 4'd1},  // R1 preset 2 window
        '{2'b00, 4'd2, 1'b1, 8'd10, 1'b1, 4'd1},
        '{2'b00, 4'd0, 1'b0, 8'd2,  1'b0, 4'd10},
        '{2'b00, 4'd0, 1'b1, 8'd1,  1'b1, 4'd10}, // R10 zero on-delay
        '{2'b00, 4'd0, 1'b0, 8'd1,  1'b0, 4'd10},
        '{2'b10, 4'd0, 1'b0, 8'd2,  1'b0, 4'd10},
        '{2'b10, 4'd0, 1'b1, 8'd1,  1'b0, 4'd10}, // R10 no pulse
        '{2'b10, 4'd0, 1'b1, 8'd3,  1'b0, 4'd10},
        '{2'b10, 4'd0, 1'b0, 8'd2,  1'b0, 4'd10}
    };

    task automatic check(input logic cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic [3:0] p, input logic e, input int w);
        mode = m; preset = PW'(p); en = e;
        repeat (w) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R12 reset state
        check(tout == 1'b0, "R12", int'(tout), 0);
        check(elapsed == '0, "R12", int'(elapsed), 0);
        rst = 1'b0;

        for (int i = 0; i < NS; i++) begin
            apply(STEPS[i].md, STEPS[i].pr, STEPS[i].e, int'(STEPS[i].wt));
            total++;
            if (tout !== STEPS[i].ex) begin
                bad++;
                $display("FAIL R%0d step %0d actual=%0d expected=%0d",
                         STEPS[i].tag, i, tout, STEPS[i].ex);
            end
        end

        // R11 saturation at limit 10
        apply(2'b00, 4'd1, 1'b0, 2);
        apply(2'b00, 4'd1, 1'b1, 60);
        check(elapsed == CW'(10), "R11", int'(elapsed), 10);
        apply(2'b00, 4'd1, 1'b1, 200);
        check(elapsed == CW'(10), "R11", int'(elapsed), 10);
        check(tout == 1'b1, "R11", int'(tout), 1);
        // R3 count cleared at the port
        apply(2'b00, 4'd1, 1'b0, 1);
        check(elapsed == '0, "R3", int'(elapsed), 0);

        // R1 count is in base ticks: 5 ticks take 20 clocks
        apply(2'b00, 4'd1, 1'b1, 21);
        check(elapsed >= CW'(4) && elapsed <= CW'(6), "R1", int'(elapsed), 5);

        // R12 reset while output high
        apply(2'b01, 4'd1, 1'b1, 3);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(tout == 1'b0, "R12", int'(tout), 0);
        check(elapsed == '0, "R12", int'(elapsed), 0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule